// File: doc/BRIEF.md
# Byte and Word Memory Lane Steering

This block sits between a 16-bit processor datapath and a memory built from 16-bit words but addressed in bytes. Each processor access is turned into a word access. The byte address loses its lane bit to become the word address. On a byte access, the lane bit picks which half of the word is touched.

Byte stores place the low byte of the register on every lane of the write bus and enable only the chosen lane. Byte loads pick the chosen lane out of the returned word and fill the upper half of the result with copies of that byte's top bit.

The memory is taken to be synchronous: it returns read data on the clock edge that accepts the request. The load result is therefore produced one cycle after the request, flagged by a valid strobe. A word access with the lane bit set is treated as misaligned. It is flagged and never reaches memory.

Top module: `mem_lane_steer`

## Requirements
- R1: For every issued access, the word address output equals the byte address with bit 0 removed (`addr_i[15:1]`).
- R2: An aligned word write (`byte_i`=0, `addr_i[0]`=0) issues a write with both enables set (`mem_be_o`=2'b11) and passes `wdata_i` unchanged to the write bus.
- R3: A byte access (`byte_i`=1) enables exactly one lane: `addr_i[0]`=0 gives `mem_be_o`=2'b01 (bits 7:0), and `addr_i[0]`=1 gives 2'b10 (bits 15:8).
- R4: On a byte write, `wdata_i[7:0]` appears on both lanes of `mem_wdata_o`, and `wdata_i[15:8]` has no effect on the stored word.
- R5: Each issued read raises `ld_valid_o` for exactly one cycle, on the cycle after the request. No other cycle raises it.
- R6: A byte load returns the lane chosen by `addr_i[0]` in bits 7:0 and fills bits 15:8 with copies of that byte's bit 7.
- R7: An aligned word load returns the memory word unchanged.
- R8: A word access with `addr_i[0]`=1 raises `align_err_o` in the same cycle and issues no memory request. A misaligned write leaves memory unchanged, and a misaligned read produces no load result.
- R9: With `req_i` low, `mem_req_o`, `mem_we_o` and `mem_be_o` are all zero.
- R10: While `rst_ni` is low, `ld_valid_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| byte_i | input | 1 | 1 = byte access, 0 = word access |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 16 | Register value to store |
| mem_rdata_i | input | 16 | Word returned by memory, one cycle after a read |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 15 | Word address |
| mem_be_o | output | 2 | Per-lane write/byte enables |
| mem_wdata_o | output | 16 | Steered write data |
| align_err_o | output | 1 | Misaligned word access |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 16 | Load result, sign-extended for bytes |

## Verification
The request-side outputs are combinational. These are the word address, lane enables, steered write data and alignment flag. The bench samples them 2 ns after driving the inputs, within the same cycle and before the accepting edge.

A load result is due on the edge after its request. The driver queues the expected word when it issues a read. A monitor samples 4 ns after every rising edge. It pops and compares an item whenever `ld_valid_o` is high, and reports an error if the strobe is high with an empty queue or low with an item waiting.

The expected memory contents are held in a bench-side shadow copy updated by the byte and word rules. Reads after writes therefore also test the write steering.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    ACC_WORD = 1'b0,
    ACC_BYTE = 1'b1
  } acc_size_e;
endpackage

// File: rtl/lane_req_map.sv
module lane_req_map
  import lane_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  localparam int unsigned NB = DW / BYTE_W,
  localparam int unsigned LW = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  acc_size_e         size_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-LW-1:0]  mem_addr_o,
  output logic [NB-1:0]     mem_be_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              align_err_o,
  output logic              rd_fire_o,
  output logic [LW-1:0]     lane_o
);
  logic [LW-1:0] lane;
  logic          issue;

  assign lane        = addr_i[LW-1:0];
  assign align_err_o = req_i && (size_i == ACC_WORD) && (lane != '0);
  assign issue       = req_i && !align_err_o;
  assign mem_req_o   = issue;
  assign mem_we_o    = issue && we_i;
  assign rd_fire_o   = issue && !we_i;
  assign mem_addr_o  = addr_i[AW-1:LW];
  assign lane_o      = lane;

  for (genvar k = 0; k < NB; k++) begin : g_lane
    logic sel;
    assign sel = (size_i == ACC_WORD) || (lane == LW'(k));
    assign mem_be_o[k] = issue && sel;
    // byte stores replicate the register low byte on every lane
    assign mem_wdata_o[k*BYTE_W +: BYTE_W] =
      (size_i == ACC_WORD) ? wdata_i[k*BYTE_W +: BYTE_W] : wdata_i[BYTE_W-1:0];
  end

  a_r3_byte_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && size_i == ACC_BYTE) |-> $countones(mem_be_o) == 1);
  a_r8_misaligned_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> (!mem_req_o && !mem_we_o && mem_be_o == '0));
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (!mem_req_o && !mem_we_o && mem_be_o == '0));
  a_r2_word_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && size_i == ACC_WORD) |-> (&mem_be_o));
endmodule

// File: rtl/lane_rd_track.sv
module lane_rd_track
  import lane_pkg::*;
#(
  parameter int unsigned LW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_fire_i,
  input  acc_size_e     size_i,
  input  logic [LW-1:0] lane_i,
  output logic          ld_valid_o,
  output acc_size_e     size_o,
  output logic [LW-1:0] lane_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_o <= 1'b0;
      size_o     <= ACC_WORD;
      lane_o     <= '0;
    end else begin
      ld_valid_o <= rd_fire_i;
      if (rd_fire_i) begin
        size_o <= size_i;
        lane_o <= lane_i;
      end
    end
  end
endmodule

// File: rtl/lane_load_ext.sv
module lane_load_ext
  import lane_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned NB = DW / BYTE_W,
  localparam int unsigned LW = $clog2(NB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  acc_size_e     size_i,
  input  logic [LW-1:0] lane_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] data_o
);
  logic [BYTE_W-1:0] pick;

  always_comb begin
    pick = rdata_i[BYTE_W-1:0];
    for (int k = 0; k < NB; k++) begin
      if (lane_i == LW'(k)) pick = rdata_i[k*BYTE_W +: BYTE_W];
    end
  end

  assign data_o = (size_i == ACC_WORD) ? rdata_i
                                       : {{(DW-BYTE_W){pick[BYTE_W-1]}}, pick};

  a_r6_sign_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == ACC_BYTE) |->
      (data_o[DW-1:BYTE_W] == {(DW-BYTE_W){data_o[BYTE_W-1]}}));
endmodule

// File: rtl/mem_lane_steer.sv
module mem_lane_steer
  import lane_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  localparam int unsigned NB = DW / BYTE_W,
  localparam int unsigned LW = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              byte_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-LW-1:0]  mem_addr_o,
  output logic [NB-1:0]     mem_be_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              align_err_o,
  output logic              ld_valid_o,
  output logic [DW-1:0]     ld_data_o
);
  acc_size_e     size, size_q;
  logic          rd_fire;
  logic [LW-1:0] lane, lane_q;

  assign size = byte_i ? ACC_BYTE : ACC_WORD;

  lane_req_map #(.AW(AW), .DW(DW)) u_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .size_i      (size),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .mem_wdata_o (mem_wdata_o),
    .align_err_o (align_err_o),
    .rd_fire_o   (rd_fire),
    .lane_o      (lane)
  );

  lane_rd_track #(.LW(LW)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_fire_i  (rd_fire),
    .size_i     (size),
    .lane_i     (lane),
    .ld_valid_o (ld_valid_o),
    .size_o     (size_q),
    .lane_o     (lane_q)
  );

  lane_load_ext #(.DW(DW)) u_ext (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (ld_valid_o),
    .size_i  (size_q),
    .lane_i  (lane_q),
    .rdata_i (mem_rdata_i),
    .data_o  (ld_data_o)
  );

  a_r5_load_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> $past(req_i && !we_i && !align_err_o));
  a_r5_read_yields_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !align_err_o) |=> ld_valid_o);
  a_r8_no_load_on_misalign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_err_o && !we_i) |=> !ld_valid_o);
endmodule

// File: tb/tb_mem_lane_steer.sv
module tb_mem_lane_steer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, byte_i = 1'b0;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic [15:0] mem_rdata_i;
  logic        mem_req_o, mem_we_o, align_err_o, ld_valid_o;
  logic [14:0] mem_addr_o;
  logic [1:0]  mem_be_o;
  logic [15:0] mem_wdata_o, ld_data_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  mem_lane_steer dut (.*);

  // word memory model, synchronous read
  logic [15:0] ram [8];
  logic [15:0] rd_q;
  assign mem_rdata_i = rd_q;
  always_ff @(posedge clk_i) begin
    if (mem_req_o) begin
      rd_q <= ram[mem_addr_o[2:0]];
      if (mem_we_o) begin
        if (mem_be_o[0]) ram[mem_addr_o[2:0]][7:0]  <= mem_wdata_o[7:0];
        if (mem_be_o[1]) ram[mem_addr_o[2:0]][15:8] <= mem_wdata_o[15:8];
      end
    end
  end

  logic [15:0] shadow [8];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(bit we, bit byt, logic [15:0] a, logic [15:0] wd);
    bit mis;
    logic [1:0] be;
    logic [15:0] w, ew;
    logic [7:0] b;
    @(negedge clk_i);
    req_i = 1; we_i = we; byte_i = byt; addr_i = a; wdata_i = wd;
    #2;
    mis = !byt && a[0];
    be = mis ? 2'b00 : (!byt ? 2'b11 : (a[0] ? 2'b10 : 2'b01));
    chk("R8 align flag", align_err_o, mis);
    chk("R8 request gating", mem_req_o, !mis);
    chk(byt ? "R3 lane enables" : "R2 lane enables", mem_be_o, be);
    if (!mis) begin
      chk("R1 word address", mem_addr_o, a[15:1]);
      chk("R2 write strobe", mem_we_o, we);
    end
    if (we && !mis) begin
      ew = byt ? {wd[7:0], wd[7:0]} : wd;
      chk(byt ? "R4 byte write data" : "R2 word write data", mem_wdata_o, ew);
      w = shadow[a[3:1]];
      if (!byt) w = wd;
      else if (a[0]) w[15:8] = wd[7:0];
      else w[7:0] = wd[7:0];
      shadow[a[3:1]] = w;
    end
    if (!we && !mis) begin
      w = shadow[a[3:1]];
      b = a[0] ? w[15:8] : w[7:0];
      exp_q.push_back(byt ? {{8{b[7]}}, b} : w);
      tag_q.push_back(byt ? "R6 byte load" : "R7 word load");
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_i = 0; we_i = 0; byte_i = 0; addr_i = 16'hFFFF; wdata_i = 16'hDEAD;
    #2;
    chk("R9 idle", {mem_req_o, mem_we_o, mem_be_o}, 4'b0000);
  endtask

  // scoreboard monitor: results due one edge after the read
  initial begin
    forever begin
      @(posedge clk_i);
      #4;
      if (rst_ni) begin
        if (ld_valid_o) begin
          if (exp_q.size() == 0) chk("R5 unexpected load", 1, 0);
          else begin
            string t;
            t = tag_q.pop_front();
            chk(t, ld_data_o, exp_q.pop_front());
          end
        end else if (exp_q.size() != 0) begin
          chk("R5 missing load", 0, 1);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin ram[i] = 16'h0; shadow[i] = 16'h0; end
    rd_q = '0;
    repeat (3) @(negedge clk_i);
    chk("R10 reset valid", ld_valid_o, 0);
    rst_ni = 1;
    idle();
    // word writes: sign patterns across both bytes
    access(1, 0, 16'h0000, 16'h80FF);
    access(1, 0, 16'h0002, 16'h7F01);
    access(1, 0, 16'h0004, 16'hFF80);
    access(1, 0, 16'h0006, 16'h017F);
    for (int a = 0; a < 8; a++) access(0, 1, 16'(a), 16'h0);   // byte loads both lanes
    for (int a = 0; a < 8; a += 2) access(0, 0, 16'(a), 16'h0); // word loads
    idle();
    // byte writes with junk upper byte, both lanes, both signs
    access(1, 1, 16'h0008, 16'hAA85);
    access(1, 1, 16'h0009, 16'h5512);
    access(1, 1, 16'h000A, 16'hFF34);
    access(1, 1, 16'h000B, 16'h00C7);
    for (int a = 8; a < 12; a++) access(0, 1, 16'(a), 16'h0);
    access(0, 0, 16'h0008, 16'h0);
    access(0, 0, 16'h000A, 16'h0);
    // misaligned word write and read
    access(1, 0, 16'h0003, 16'hBEEF);
    access(0, 0, 16'h0003, 16'h0);
    idle();
    access(0, 0, 16'h0002, 16'h0);
    access(0, 1, 16'h0003, 16'h0);
    // full sweep: every size, lane and sign
    for (int s = 0; s < 2; s++) begin
      for (int a = 12; a < 16; a++) begin
        access(1, 0, 16'(a & ~1), s ? 16'h8080 : 16'h7F7F);
        access(1, 1, 16'(a), s ? 16'h1290 : 16'h9210);
        access(0, 1, 16'(a), 16'h0);
        access(0, 1, 16'(a ^ 1), 16'h0);
        access(0, 0, 16'(a), 16'h0);
      end
    end
    idle();
    idle();
    chk("R5 queue drained", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule